// File: doc/BRIEF.md
# External Interrupt Request Detector

This block turns one active-low external interrupt pin into a single request flag for an interrupt controller. It looks at the pin only once per machine cycle. A machine cycle is marked by a one-clock strobe that the block makes itself, once every `OSC_PER_MC` clocks (12 by default).

A mode input selects how the flag is raised. In level mode the flag takes the inverted pin value at every machine-cycle strobe, so a pin held low keeps the request up. In falling-transition mode the flag is set only when one strobe sample reads high and the next reads low. It then stays set until the controller acknowledges the vector or software clears it.

Software can read the flag and can overwrite it at any time. A hardware set that lands in the same clock as a software write always wins.

Top module: `extint_req_detect`

## Requirements
- R1: After synchronous reset, `req_flag` is 0 and `mc_tick` is 0. The first `mc_tick` pulse appears `OSC_PER_MC`-1 clocks after the first clock edge with `rst_n` high.
- R2: `mc_tick` is high for exactly one clock in every `OSC_PER_MC` clocks.
- R3: With `trig_fall` = 0 (level mode), at every clock edge where `mc_tick` is high, `req_flag` becomes the inverse of `int_pin_n`. A low pin raises the flag and a high pin lowers it.
- R4: Pin activity between strobes has no effect. With no strobe, no software write, and no acknowledge in transition mode, `req_flag` holds its value.
- R5: With `trig_fall` = 1 (transition mode), `req_flag` is set at a strobe where the pin is low and the previous strobe sample was high. The flag stays set while the pin stays low.
- R6: In transition mode, a pin held low never sets the flag again after it is cleared. The sample history starts at "low" after reset, so a pin that is already low at reset produces no request until it has been sampled high.
- R7: `vec_ack` clears `req_flag` in transition mode. In level mode `vec_ack` has no effect.
- R8: A pulse on `flag_wr` loads `flag_wdata` into `req_flag` at the next clock edge. If a hardware set occurs in that same clock, the flag is 1.
- R9: In transition mode, a high pulse that starts and ends between two strobes is not seen as an edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| int_pin_n | input | 1 | Active-low external interrupt pin, already synchronised |
| trig_fall | input | 1 | 0 = level mode, 1 = falling-transition mode |
| vec_ack | input | 1 | One-clock pulse when the controller vectors to this source |
| flag_wr | input | 1 | Software write strobe for the flag |
| flag_wdata | input | 1 | Value written by software |
| mc_tick | output | 1 | Machine-cycle strobe, one clock wide |
| req_flag | output | 1 | Request flag, readable status |

## Verification
Four corner cases need their own tests. The first is a low pulse or a high pulse that fits between two strobes. A design that watched the pin every clock would raise a false request here, or miss one. The second is a software clear that lands in the same clock as a strobe that sets the flag. A design with the wrong priority would drop a real interrupt. The third is an acknowledge in level mode, which must leave the flag alone; a design that cleared it would lose a software-set request until the next strobe. The fourth is a reset taken while the pin is low in transition mode. A sample history that started high would create a spurious request at the first strobe.

// File: rtl/extint_pkg.sv
// Package: shared trigger-mode type for the external interrupt detector.
// Assumes: nothing beyond 1-bit mode encoding (0 level, 1 falling edge).
package extint_pkg;

    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_FALL  = 1'b1
    } trig_mode_e;

endpackage

// File: rtl/mc_tick_gen.sv
// Module: machine-cycle strobe generator.
// Produces a one-clock strobe once every OSC_PER_MC clocks.
// Assumes: OSC_PER_MC >= 2; synchronous active-low reset.
module mc_tick_gen #(
    parameter int unsigned OSC_PER_MC = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = (OSC_PER_MC > 1) ? $clog2(OSC_PER_MC) : 1;
    localparam logic [CW-1:0] LAST = CW'(OSC_PER_MC - 1);

    logic [CW-1:0] cnt;

    // Count clocks within one machine cycle, wrapping at LAST.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/pin_sampler.sv
// Module: per-machine-cycle pin sampler.
// Keeps the previous strobe sample. Reports a low or a high-to-low
// transition at each strobe.
// Assumes: pin_n is already synchronised to clk; history resets to low.
module pin_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pin_n,
    output logic low_now,
    output logic fall_now
);
    logic prev_hi;

    // Remember the pin level seen at the latest strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)    prev_hi <= 1'b0;
        else if (tick) prev_hi <= pin_n;
    end

    assign low_now  = tick & ~pin_n;
    assign fall_now = tick & prev_hi & ~pin_n;

endmodule

// File: rtl/req_flag_reg.sv
// Module: request flag register.
// Merges the hardware set, the software write, the level-mode strobe
// clear and the transition-mode acknowledge clear into one flag.
// Priority: hardware set > software write > strobe clear / acknowledge.
// Assumes: low_now and fall_now are only high in a strobe clock.
module req_flag_reg
    import extint_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  trig_mode_e mode,
    input  logic       tick,
    input  logic       low_now,
    input  logic       fall_now,
    input  logic       ack,
    input  logic       wr,
    input  logic       wdata,
    output logic       flag
);
    logic hw_set;
    logic flag_nxt;

    assign hw_set = (mode == TRIG_FALL) ? fall_now : low_now;

    // Choose the next flag value in priority order.
    always_comb begin
        if (hw_set)                             flag_nxt = 1'b1;
        else if (wr)                            flag_nxt = wdata;
        else if (mode == TRIG_LEVEL && tick)    flag_nxt = 1'b0;
        else if (mode == TRIG_FALL && ack)      flag_nxt = 1'b0;
        else                                    flag_nxt = flag;
    end

    // Hold the request flag.
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= flag_nxt;
    end

    // R3
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TRIG_LEVEL && tick && !wr) |=> (flag == $past(low_now)));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr && !(mode == TRIG_FALL && ack)) |=> $stable(flag));

    // R5
    fall_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TRIG_FALL && fall_now) |=> flag);

    // R7
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TRIG_FALL && ack && !fall_now && !wr) |=> !flag);

    // R7
    level_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TRIG_LEVEL && ack && !tick && !wr) |=> $stable(flag));

    // R8
    sw_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !hw_set) |=> (flag == $past(wdata)));

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_set |=> flag);

endmodule

// File: rtl/extint_req_detect.sv
// Module: external interrupt request detector (top).
// Samples an active-low pin once per machine cycle. Raises a request in
// level or falling-transition mode and exposes the flag to software.
// Assumes: pin is synchronised upstream; vec_ack is a one-clock pulse.
module extint_req_detect #(
    parameter int unsigned OSC_PER_MC = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic int_pin_n,
    input  logic trig_fall,
    input  logic vec_ack,
    input  logic flag_wr,
    input  logic flag_wdata,
    output logic mc_tick,
    output logic req_flag
);
    import extint_pkg::*;

    trig_mode_e mode;
    logic       low_now;
    logic       fall_now;

    assign mode = trig_mode_e'(trig_fall);

    mc_tick_gen #(.OSC_PER_MC(OSC_PER_MC)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (mc_tick)
    );

    pin_sampler u_samp (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (mc_tick),
        .pin_n    (int_pin_n),
        .low_now  (low_now),
        .fall_now (fall_now)
    );

    req_flag_reg u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .tick     (mc_tick),
        .low_now  (low_now),
        .fall_now (fall_now),
        .ack      (vec_ack),
        .wr       (flag_wr),
        .wdata    (flag_wdata),
        .flag     (req_flag)
    );

endmodule

// File: tb/extint_req_detect_bench.sv
module extint_req_detect_bench;
    localparam int DIV = 12;

    typedef struct {
        logic  flag;
        logic  tick;
        string tag;
    } exp_item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin_b = 1'b1;
    logic mode_b = 1'b0;
    logic ack_b = 1'b0;
    logic wr_b = 1'b0;
    logic wd_b = 1'b0;
    logic mc_tick;
    logic req_flag;

    int checks = 0;
    int failures = 0;
    exp_item_t q[$];

    // bench-side model state, derived from the requirements
    int   bcnt = 0;
    logic m_flag = 1'b0;
    logic m_prev_hi = 1'b0;
    string tag = "R1";

    always #5 clk = ~clk;

    extint_req_detect #(.OSC_PER_MC(DIV)) u_extint_req_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .int_pin_n  (pin_b),
        .trig_fall  (mode_b),
        .vec_ack    (ack_b),
        .flag_wr    (wr_b),
        .flag_wdata (wd_b),
        .mc_tick    (mc_tick),
        .req_flag   (req_flag)
    );

    // monitor: pop one expected item per clock and compare
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_item_t e;
            e = q.pop_front();
            checks++;
            if (req_flag !== e.flag || mc_tick !== e.tick) begin
                failures++;
                $display("FAIL %s: flag/tick actual=%b/%b expected=%b/%b at %0t",
                         e.tag, req_flag, mc_tick, e.flag, e.tick, $time);
            end
        end
    end

    // driver: advance n clocks, pushing the expected outcome of each
    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            logic tk;
            logic set;
            tk  = (bcnt == DIV - 1);
            set = tk && (mode_b ? (m_prev_hi && !pin_b) : !pin_b);
            if (set)                m_flag = 1'b1;
            else if (wr_b)          m_flag = wd_b;
            else if (!mode_b && tk) m_flag = 1'b0;
            else if (mode_b && ack_b) m_flag = 1'b0;
            if (tk) m_prev_hi = pin_b;
            bcnt = (bcnt + 1) % DIV;
            q.push_back('{m_flag, (bcnt == DIV - 1), tag});
            @(negedge clk); #1;
        end
    endtask

    // advance until the next clock carries the strobe
    task automatic align();
        while (bcnt != DIV - 1) step(1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        checks++;
        if (req_flag !== 1'b0 || mc_tick !== 1'b0) begin
            failures++;
            $display("FAIL R1: reset flag/tick actual=%b/%b expected=0/0",
                     req_flag, mc_tick);
        end
        rst_n = 1'b1;
        bcnt = 0; m_flag = 1'b0; m_prev_hi = 1'b0;
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();
        // R1 / R2: first strobe timing and strobe period, level mode idle
        tag = "R2"; mode_b = 1'b0; pin_b = 1'b1;
        step(30);
        // R3: low pin raises, high pin lowers at strobes
        tag = "R3"; pin_b = 1'b0; step(24);
        pin_b = 1'b1; step(12);
        // R4: low pulse between strobes ignored
        tag = "R4"; align(); step(1);
        pin_b = 1'b0; step(8); pin_b = 1'b1; step(10);
        // R8: software write takes effect at once
        tag = "R8"; align(); step(1);
        wr_b = 1'b1; wd_b = 1'b1; step(1); wr_b = 1'b0; step(1);
        // R7: ack in level mode has no effect
        tag = "R7"; ack_b = 1'b1; step(1); ack_b = 1'b0; step(2);
        tag = "R3"; align(); step(2);
        // R8: hardware set beats software clear (level mode)
        tag = "R8"; align(); pin_b = 1'b0; wr_b = 1'b1; wd_b = 1'b0;
        step(1); wr_b = 1'b0; pin_b = 1'b1; step(14);
        // R5: falling transition sets and holds
        tag = "R5"; mode_b = 1'b1; pin_b = 1'b1; step(24);
        pin_b = 1'b0; step(24);
        // R7: acknowledge clears in transition mode
        tag = "R7"; ack_b = 1'b1; step(1); ack_b = 1'b0;
        // R6: held low does not re-set
        tag = "R6"; step(30);
        // R8: set beats clear (transition mode)
        tag = "R8"; pin_b = 1'b1; step(12); align();
        pin_b = 1'b0; wr_b = 1'b1; wd_b = 1'b0; step(1); wr_b = 1'b0; step(3);
        wr_b = 1'b1; wd_b = 1'b0; step(1); wr_b = 1'b0; step(2);
        // R9: short high pulse between strobes not an edge
        tag = "R9"; align(); step(1);
        pin_b = 1'b1; step(6); pin_b = 1'b0; step(30);
        // R6: reset while pin low, transition mode
        tag = "R6"; mode_b = 1'b1; pin_b = 1'b0;
        do_reset();
        step(40);
        tag = "R5"; pin_b = 1'b1; step(12); pin_b = 1'b0; step(14);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule